// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block watches for a hung system with a 32-bit down counter. Once software enables it, the counter counts down once per clock. The first time the counter reaches zero, the block raises an interrupt, reloads the counter from its load value and keeps counting. If the counter runs out a second time while that interrupt is still pending, and reset generation is enabled, the block drives a system reset. That reset stays asserted until the block itself is reset.

Software controls the block through a simple synchronous register bus. Register reads are combinational. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A lock register protects the load value and the enables. The interrupt-clear address is exempt from the lock, so the service routine always works.

Word addresses on `bus_addr`:
- 0: load value (read/write)
- 1: live counter (read only)
- 2: control. Bit 0 is the counter and interrupt enable; bit 1 is the reset enable.
- 3: interrupt clear (write only)
- 4: raw status, bit 0
- 5: masked status, bit 0
- 6: lock

Top module: `wdog_twostage`

## Requirements
- R1: After `rst_n` is released: the counter reads 0xFFFFFFFF, the load register reads 0xFFFFFFFF, control reads 0, lock reads 0, and `irq_o` and `sys_rst_o` are low.
- R2: While control bit 0 is set, the counter drops by one on every clock. While bit 0 is clear, the counter holds its value.
- R3: Suppose the counter holds 0 while enabled and no interrupt is pending. On the next edge, the raw status bit 0 and `irq_o` go high, and the counter reloads from the load register. With load value L, `irq_o` first rises L+1 edges after the edge that wrote the enable.
- R4: Suppose the counter holds 0 while enabled and an interrupt is already pending. If control bit 1 is set, `sys_rst_o` goes high on the next edge. If bit 1 is clear, no reset is raised and counting continues from the load value.
- R5: A write of any data to address 3 clears the pending interrupt and reloads the counter from the load register on the same edge. This write also wins over a zero crossing on the same edge.
- R6: A write to address 0 while unlocked updates the load register and the counter on the same edge. A pending interrupt is left set.
- R7: Any write to control with bit 0 set reloads the counter from the load register. The counter does not resume from its old value.
- R8: Writing the unlock key (default 0x1ACCE551) to address 6 unlocks the block, and lock reads 0. Writing any other value locks it, and lock reads 1. While locked, writes to addresses 0 and 2 change nothing.
- R9: A write to address 3 clears the pending interrupt even while the block is locked.
- R10: Once set, control bit 0 stays set until `rst_n` is asserted. Control bit 1 can be both set and cleared by writes while unlocked.
- R11: Once `sys_rst_o` is high, it stays high until `rst_n` is asserted, regardless of bus writes.
- R12: Address 4 bit 0 returns the pending interrupt. Address 5 bit 0 returns the pending interrupt ANDed with the enable, and `irq_o` equals that value.
- R13: If a load write and a zero crossing fall on the same edge, the counter takes the written value. The interrupt and reset decisions still follow the zero crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Masked interrupt request |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The assertions are checked on every clock:
- the counter steps down by one per clock while enabled and holds while disabled;
- locked writes leave the load value unchanged;
- a clear always leaves no interrupt pending;
- the enable and the reset output never fall back without `rst_n`;
- an interrupt is never pending while the block is disabled.

Some behaviours can only be shown by the bench's scenarios:
- the exact edge count from the enable write to the first interrupt;
- the second-expiry reset, with and without the reset enable;
- the lock key handling;
- the collision between a load write and a zero crossing.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int          CW  = 32,
  parameter int          AW  = 3,
  parameter logic [CW-1:0] KEY = 32'h1ACC_E551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          sys_rst_o
);
  localparam logic [AW-1:0] A_LOAD = 3'd0, A_CNT = 3'd1, A_CTRL = 3'd2,
                            A_CLR = 3'd3, A_RAW = 3'd4, A_MSK = 3'd5, A_LOCK = 3'd6;
  localparam logic [CW-1:0] ONES = {CW{1'b1}};

  logic [CW-1:0] cnt_q, load_q;
  logic en_q, rst_en_q, pend_q, locked_q, sysrst_q;

  wire wr      = bus_sel & bus_wr;
  wire wr_load = wr & (bus_addr == A_LOAD) & ~locked_q;
  wire wr_ctrl = wr & (bus_addr == A_CTRL) & ~locked_q;
  wire wr_clr  = wr & (bus_addr == A_CLR);
  wire wr_lock = wr & (bus_addr == A_LOCK);
  wire zero    = en_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= ONES;
      load_q   <= ONES;
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
      sysrst_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= bus_wdata;
      if (wr_ctrl) begin
        en_q     <= en_q | bus_wdata[0];
        rst_en_q <= bus_wdata[1];
      end
      if (wr_lock) locked_q <= (bus_wdata != KEY);

      if (wr_clr)    pend_q <= 1'b0;
      else if (zero) pend_q <= 1'b1;

      if (zero && pend_q && rst_en_q && !wr_clr) sysrst_q <= 1'b1;

      if (wr_load)                      cnt_q <= bus_wdata;
      else if (wr_ctrl && bus_wdata[0]) cnt_q <= load_q;
      else if (wr_clr || zero)          cnt_q <= load_q;
      else if (en_q)                    cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LOAD:  bus_rdata = load_q;
      A_CNT:   bus_rdata = cnt_q;
      A_CTRL:  bus_rdata[1:0] = {rst_en_q, en_q};
      A_RAW:   bus_rdata[0] = pend_q;
      A_MSK:   bus_rdata[0] = pend_q & en_q;
      A_LOCK:  bus_rdata[0] = locked_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = pend_q & en_q;
  assign sys_rst_o = sysrst_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q != '0 && !wr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr) |=> $stable(cnt_q)); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !pend_q); // R5
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr && bus_addr == A_LOAD) |=> $stable(load_q)); // R8
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R10
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_q |=> sysrst_q); // R11
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> en_q); // R12
endmodule

// File: tb/wdog_twostage_test.sv
module wdog_twostage_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, sys_rst_o;
  int checks = 0, errors = 0;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  always #4 clk = ~clk;

  wdog_twostage uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(1, v); check("R1 count", v, 32'hFFFF_FFFF);
    rd(0, v); check("R1 load", v, 32'hFFFF_FFFF);
    rd(2, v); check("R1 ctrl", v, 0);
    rd(6, v); check("R1 lock", v, 0);
    check("R1 irq", irq_o, 0);
    check("R1 sysrst", sys_rst_o, 0);
    wait_n(5);
    rd(1, v); check("R2 hold when disabled", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_first_timeout();
    logic [31:0] v;
    do_reset();
    wr(0, 10);
    wr(2, 1);
    rd(1, v); check("R7 preload on enable", v, 10);
    wait_n(4);
    rd(1, v); check("R2 decrement", v, 6);
    wait_n(6);
    rd(1, v); check("R3 at zero", v, 0);
    check("R3 no irq yet", irq_o, 0);
    wait_n(1);
    check("R3 irq", irq_o, 1);
    rd(1, v); check("R3 reload", v, 10);
    rd(4, v); check("R12 raw", v, 1);
    rd(5, v); check("R12 masked", v, 1);
    wr(0, 50);
    rd(1, v); check("R6 load into counter", v, 50);
    rd(4, v); check("R6 pending kept", v, 1);
    wr(3, 32'h1234_5678);
    rd(4, v); check("R5 cleared", v, 0);
    check("R5 irq low", irq_o, 0);
    rd(1, v); check("R5 reload", v, 50);
    wait_n(5);
    wr(2, 1);
    rd(1, v); check("R7 re-enable preload", v, 50);
  endtask

  task automatic t_second_timeout();
    logic [31:0] v;
    do_reset();
    wr(0, 3);
    wr(2, 1);
    wait_n(8);
    check("R4 no reset without enable", sys_rst_o, 0);
    rd(1, v); check("R4 counting continues", v, 3);
    rd(4, v); check("R4 still pending", v, 1);
    do_reset();
    wr(0, 3);
    wr(2, 3);
    wait_n(7);
    check("R4 not yet", sys_rst_o, 0);
    wait_n(1);
    check("R4 reset raised", sys_rst_o, 1);
    wr(3, 0);
    wr(0, 100);
    wait_n(10);
    check("R11 sticky", sys_rst_o, 1);
    do_reset();
    check("R11 released by rst_n", sys_rst_o, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(0, 4);
    wr(2, 1);
    wait_n(5);
    check("R9 pending before lock", irq_o, 1);
    wr(6, 32'h0);
    rd(6, v); check("R8 locked", v, 1);
    wr(0, 77);
    rd(0, v); check("R8 load ignored", v, 4);
    wr(2, 2);
    rd(2, v); check("R8 ctrl ignored", v, 1);
    wr(3, 32'hDEAD);
    rd(4, v); check("R9 clear while locked", v, 0);
    wr(6, KEY);
    rd(6, v); check("R8 unlocked", v, 0);
    wr(0, 77);
    rd(0, v); check("R8 load accepted", v, 77);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] v;
    do_reset();
    wr(2, 3);
    rd(2, v); check("R10 both set", v, 3);
    wr(2, 0);
    rd(2, v); check("R10 enable sticky, reset enable cleared", v, 1);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    do_reset();
    wr(0, 10);
    wr(2, 1);
    wait_n(10);
    rd(1, v); check("R13 at zero", v, 0);
    wr(0, 5);
    rd(1, v); check("R13 written value wins", v, 5);
    rd(4, v); check("R13 irq from zero", v, 1);
  endtask

  initial begin
    t_reset_state();
    t_first_timeout();
    t_second_timeout();
    t_lock();
    t_ctrl_bits();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule